// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Edge Interrupts

This block is a bank of 32 general-purpose pins grouped as four ports of eight, with direction, output latch, interrupt status and interrupt select registers on a 32-bit register bus. Each pin can be driven from its latch or used as an input. Every input passes through a two-flop synchroniser. A per-pin 2-bit select field arms the pin for falling edges, rising edges or both. A detected edge on an armed pin sets a sticky status bit. Software clears that bit by writing a one to it.

All status bits whose pin is still armed are ORed into a single interrupt line. The register bus is word-addressed: `bus_word` is the byte offset divided by four. A write is one cycle of `bus_wr` with per-byte enables. Read data is combinational from `bus_word`.

A static input, `rev_order`, selects where each port's bits sit inside the 32-bit words. In normal order port 0 is in the low byte. In reversed order the byte and half-word placement is mirrored.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: Word 2 (byte offset 0x08) is the direction register and word 3 (0x0C) is the output latch. A pin with direction bit 1 has `pin_oe` 1 and drives `pin_out` from its latch bit. A pin with direction bit 0 has `pin_oe` 0.
- R3: Reading word 3 returns the latch bit for output pins and the synchronised pin level for input pins. A pin change becomes visible after two clock edges.
- R4: Pin p's select field lies at bits 2p+1:2p of its port's 16-bit half-word in words 5 (0x14) and 6 (0x18). The codes are: 0 = off, 1 = falling edge, 2 = rising edge, 3 = both edges. Only a selected edge sets the pin's status bit.
- R5: Word 4 (0x10) is the status register. Its bits stay set until written with 1. Writing 0 to a bit leaves it unchanged, and no other register write clears it.
- R6: If a new edge and a write-1 clear of the same bit land on the same clock edge, the bit stays set.
- R7: `irq` is high exactly when some pin has its status bit set and a non-zero select field. Setting the field to 0 drops `irq` but leaves the status bit.
- R8: A pin edge sets its status bit on the third rising clock edge after the pin changes, and not on the second.
- R9: With `rev_order`=0, port N's byte in words 2, 3 and 4 is at bits 8N+7:8N. Ports 0 and 1 are the low and high halves of word 5, and ports 2 and 3 are the low and high halves of word 6.
- R10: With `rev_order`=1, port N's byte in words 2, 3 and 4 is at bits 8(3-N)+7:8(3-N). Ports 0 and 1 are the high and low halves of word 5, and ports 2 and 3 are the high and low halves of word 6.
- R11: A write changes only the bus bytes whose `bus_be` bit is set.
- R12: Word 0 (0x00) is a read/write storage word with no effect on the pins. Unused words 1 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_order | input | 1 | Static: 1 selects reversed port placement |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data for `bus_word` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench times a write-1 clear to land on the same edge as a fresh falling edge. A design where the clear wins would lose that interrupt. It samples status one edge before and one edge after the expected set point, which exposes a missing or extra synchroniser stage. It arms the same pins with each of the four select codes, so that swapped rising and falling bits or wrong field positions show up as wrong status bits. Both port placements are exercised through direction, status and select words, and a half-word swap done the wrong way round would show up as an interrupt on the wrong port.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rev_order,
  input  logic        bus_wr,
  input  logic [2:0]  bus_word,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic        irq
);
  localparam int NPIN = 32;

  localparam logic [2:0] W_CTRL = 3'd0;
  localparam logic [2:0] W_DIR  = 3'd2;
  localparam logic [2:0] W_DATA = 3'd3;
  localparam logic [2:0] W_STAT = 3'd4;
  localparam logic [2:0] W_MLO  = 3'd5;
  localparam logic [2:0] W_MHI  = 3'd6;

  function automatic logic [31:0] lane_map(input logic [31:0] v, input logic r);
    return r ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
  endfunction

  function automatic logic [31:0] half_map(input logic [31:0] v, input logic r);
    return r ? {v[15:0], v[31:16]} : v;
  endfunction

  function automatic logic [31:0] bytes_to_bits(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  logic [31:0] ctrl_q, dir_q, dout_q, stat_q;
  logic [63:0] mask_q;
  logic [NPIN-1:0] s1_q, s2_q, s3_q;
  logic [NPIN-1:0] en_rise, en_fall, hit, clr;
  logic [31:0] wl_lane, bm_lane, wl_half, bm_half, raw_be;

  assign raw_be  = bytes_to_bits(bus_be);
  assign wl_lane = lane_map(bus_wdata, rev_order);
  assign bm_lane = lane_map(raw_be, rev_order);
  assign wl_half = half_map(bus_wdata, rev_order);
  assign bm_half = half_map(raw_be, rev_order);

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      en_fall[p] = mask_q[2*p];
      en_rise[p] = mask_q[2*p+1];
    end
  end

  assign hit = (s2_q & ~s3_q & en_rise) | (~s2_q & s3_q & en_fall);
  assign clr = (bus_wr && bus_word == W_STAT) ? (wl_lane & bm_lane) : '0;
  assign irq = |(stat_q & (en_rise | en_fall));

  assign pin_oe  = dir_q;
  assign pin_out = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_word)
        W_CTRL: ctrl_q <= (ctrl_q & ~raw_be) | (bus_wdata & raw_be);
        W_DIR:  dir_q  <= (dir_q & ~bm_lane) | (wl_lane & bm_lane);
        W_DATA: dout_q <= (dout_q & ~bm_lane) | (wl_lane & bm_lane);
        W_MLO:  mask_q[31:0]  <= (mask_q[31:0] & ~bm_half) | (wl_half & bm_half);
        W_MHI:  mask_q[63:32] <= (mask_q[63:32] & ~bm_half) | (wl_half & bm_half);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | hit;
  end

  always_comb begin
    case (bus_word)
      W_CTRL:  bus_rdata = ctrl_q;
      W_DIR:   bus_rdata = lane_map(dir_q, rev_order);
      W_DATA:  bus_rdata = lane_map((dir_q & dout_q) | (~dir_q & s2_q), rev_order);
      W_STAT:  bus_rdata = lane_map(stat_q, rev_order);
      W_MLO:   bus_rdata = half_map(mask_q[31:0], rev_order);
      W_MHI:   bus_rdata = half_map(mask_q[63:32], rev_order);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_word,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic [31:0] stat_q,
  input logic [63:0] mask_q
);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_word == 3'd4) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0 && mask_q != '0));

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && stat_q == '0) |=> stat_q == '0);

  a_r12_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == 3'd1 || bus_word == 3'd7) |-> bus_rdata == '0);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_rdata(bus_rdata), .irq(irq), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rev_order = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_edge_bank dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_word = w; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    bus_word = w;
    #1 d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      rd(w[2:0], d);
      check("R1 reg", d, 32'h0);
    end
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_dir_data;
    logic [31:0] d;
    pin_in = 32'h5A5A_0000;
    wr(3'd2, 32'h0000_FFFF, 4'hF);
    wr(3'd3, 32'hA5A5_3C3C, 4'hF);
    edges(2);
    check("R2 oe", pin_oe, 32'h0000_FFFF);
    check("R2 out", pin_out, 32'hA5A5_3C3C);
    rd(3'd3, d);
    check("R3 data read", d, 32'h5A5A_3C3C);
    pin_in = 32'h0F0F_0000;
    edges(1);
    rd(3'd3, d);
    check("R3 one edge", d, 32'h5A5A_3C3C);
    edges(1);
    rd(3'd3, d);
    check("R3 two edges", d, 32'h0F0F_3C3C);
    pin_in = '0;
    wr(3'd2, 32'h0, 4'hF);
    wr(3'd2, 32'hFFFF_FFFF, 4'b0100);
    rd(3'd2, d);
    check("R11 byte enable", d, 32'h00FF_0000);
    wr(3'd2, 32'h0, 4'hF);
    wr(3'd3, 32'h0, 4'hF);
    edges(3);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(3'd0, 32'h1234_5678, 4'hF);
    rd(3'd0, d);
    check("R12 ctrl readback", d, 32'h1234_5678);
    check("R12 ctrl no pin effect", pin_oe, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF, 4'hF);
    rd(3'd1, d);
    check("R12 hole", d, 32'h0);
    wr(3'd0, 32'h0, 4'hF);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(3'd5, 32'h0000_0036, 4'hF);
    pin_in = 32'h0000_000F;
    edges(2);
    rd(3'd4, d);
    check("R8 not yet", d, 32'h0);
    edges(1);
    rd(3'd4, d);
    check("R4 rising set", d, 32'h0000_0005);
    check("R7 irq high", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'h0, 4'hF);
    rd(3'd4, d);
    check("R5 write zero", d, 32'h0000_0005);
    wr(3'd4, 32'h0000_0005, 4'hF);
    rd(3'd4, d);
    check("R5 w1c", d, 32'h0);
    check("R7 irq low", {31'h0, irq}, 32'h0);
    pin_in = '0;
    edges(3);
    rd(3'd4, d);
    check("R4 falling set", d, 32'h0000_0006);
    wr(3'd5, 32'h0, 4'hF);
    check("R7 unarmed irq", {31'h0, irq}, 32'h0);
    rd(3'd4, d);
    check("R7 status kept", d, 32'h0000_0006);
    wr(3'd4, 32'hFFFF_FFFF, 4'hF);
  endtask

  task automatic t_coincide;
    logic [31:0] d;
    wr(3'd5, 32'h0000_0003, 4'hF);
    pin_in = 32'h1;
    edges(3);
    rd(3'd4, d);
    check("R6 setup", d, 32'h1);
    pin_in = 32'h0;
    edges(2);
    wr(3'd4, 32'h1, 4'hF);
    rd(3'd4, d);
    check("R6 edge beats clear", d, 32'h1);
    wr(3'd4, 32'h1, 4'hF);
    rd(3'd4, d);
    check("R6 later clear", d, 32'h0);
    wr(3'd5, 32'h0, 4'hF);
  endtask

  task automatic t_normal_ports;
    logic [31:0] d;
    wr(3'd6, 32'h0002_0000, 4'hF);
    pin_in = 32'h0100_0000;
    edges(3);
    rd(3'd4, d);
    check("R9 port3 status", d, 32'h0100_0000);
    check("R9 irq", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'h0100_0000, 4'hF);
    wr(3'd6, 32'h0, 4'hF);
    pin_in = '0;
    edges(3);
  endtask

  task automatic t_reversed;
    logic [31:0] d;
    rev_order = 1'b1;
    wr(3'd2, 32'h0000_00FF, 4'b0001);
    check("R10 dir lane", pin_oe, 32'hFF00_0000);
    wr(3'd5, 32'h0002_0000, 4'hF);
    wr(3'd6, 32'h0002_0000, 4'hF);
    rd(3'd5, d);
    check("R10 mask readback", d, 32'h0002_0000);
    pin_in = 32'h0001_0001;
    edges(3);
    rd(3'd4, d);
    check("R10 status lanes", d, 32'h0100_0100);
    wr(3'd4, 32'h0100_0100, 4'hF);
    rd(3'd4, d);
    check("R10 clear", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_data();
    t_ctrl();
    t_edges();
    t_coincide();
    t_normal_ports();
    t_reversed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule